// File: doc/BRIEF.md
# Sixteen-Bit Timer with Byte-Wide Register Access

The block is a 16-bit up-counter with two 16-bit compare channels, A and B, all reached through an 8-bit register port. A single 8-bit staging register holds the upper byte of every 16-bit transfer. It is shared by the counter and both compare registers, so the two halves of a value always take effect together. On a write the upper byte is staged first, and writing the lower byte commits both bytes. On a read, reading the lower byte captures the matching upper byte at the same moment, and a later read of the upper byte returns that captured value.

The counter advances only on cycles where the tick enable input is high. On each tick the counter is compared with both compare registers. A match sets the channel's interrupt flag and, if that channel's toggle is enabled, inverts its waveform output. In wrap mode the counter rolls over from 0xFFFF to 0x0000. In clear mode, compare A acts as the ceiling and the counter returns to zero after a match on A.

Writing the counter suppresses all matches on the next tick. Software can also force a channel's waveform output to invert without a real match. A forced toggle never sets a flag and never clears the counter.

Top module: `tmr16_bytebus`

## Requirements
- R1: After reset the counter, both compare registers, the staging register, the control bits, both flags and both waveform outputs are zero, and every address reads 0x00.
- R2: A write to an upper-byte address (3 counter, 5 compare A, 7 compare B) loads only the shared staging register. A write to the matching lower-byte address (2, 4, 6) loads {staging, wdata} into the target in that cycle, whichever upper-byte address last filled the staging register.
- R3: With rd_en high, a lower-byte address returns the live lower byte on rdata and copies the live upper byte of that register into the staging register at the clock edge. Any upper-byte address returns the staging register.
- R4: The counter changes only on cycles where tick is high or the counter is written; a tick at 0xFFFF gives 0x0000 in wrap mode.
- R5: In clear mode (control bit 0 set), a tick while the counter equals compare A with matching enabled loads zero instead of the incremented value.
- R6: A tick with matching enabled and counter equal to a compare register sets that channel's flag (flag register bit 0 = A, bit 1 = B, also driven on irq_a / irq_b) and inverts its waveform output when its toggle enable is set (control bit 1 = A, bit 2 = B).
- R7: A counter write disables matching, for both channels, on the next tick only: that tick sets no flag, toggles no output and does not clear the counter.
- R8: Writing control bit 6 (A) or 7 (B) inverts that channel's waveform output once, sets no flag, leaves the counter unchanged, and these bits always read back as zero.
- R9: Writing one to a flag bit clears it; a match on the same cycle wins and leaves the flag set.
- R10: Address 0 holds the control bits (bit 0 clear mode, bits 1 and 2 toggle enables), address 1 the flags; reads are combinational and return 0x00 when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| tick | input | 1 | Timer tick enable |
| irq_a | output | 1 | Channel A match flag |
| irq_b | output | 1 | Channel B match flag |
| wave_a | output | 1 | Channel A waveform output |
| wave_b | output | 1 | Channel B waveform output |

## Verification
The assertions assume that wr_en and rd_en are never high together, that addr is stable while a strobe is high, and that the reset is held across at least one clock edge before any strobe. The stimulus changes every input only on the falling edge and drives one bus operation per cycle. It raises tick together with a write in exactly one directed case, the flag clear that collides with a match. Stimulus that brings the counter up to a compare value always goes through a counter write, so each such sequence also passes through the suppressed tick.

// File: rtl/tmr16_bytebus.sv
module tmr16_bytebus (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick,
  output logic       irq_a,
  output logic       irq_b,
  output logic       wave_a,
  output logic       wave_b
);
  localparam int BW = 8;
  localparam int CW = 2 * BW;
  localparam logic [2:0] A_CTRL = 3'd0, A_FLAG = 3'd1, A_CNTL = 3'd2, A_CNTH = 3'd3,
                         A_CMAL = 3'd4, A_CMAH = 3'd5, A_CMBL = 3'd6, A_CMBH = 3'd7;

  logic [CW-1:0] cnt, cmp_a, cmp_b;
  logic [BW-1:0] stg;
  logic ctc, ten_a, ten_b, blk;
  logic wr_cnt, wr_ctrl, wr_hi, live, hit_a, hit_b, clr_a, clr_b, frc_a, frc_b;

  assign wr_cnt  = wr_en && addr == A_CNTL;
  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign wr_hi   = wr_en && (addr == A_CNTH || addr == A_CMAH || addr == A_CMBH);
  assign live    = tick && !blk;
  assign hit_a   = live && cnt == cmp_a;
  assign hit_b   = live && cnt == cmp_b;
  assign clr_a   = wr_en && addr == A_FLAG && wdata[0];
  assign clr_b   = wr_en && addr == A_FLAG && wdata[1];
  assign frc_a   = wr_ctrl && wdata[6];
  assign frc_b   = wr_ctrl && wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (wr_cnt) begin
      cnt <= {stg, wdata};
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= (ctc && hit_a) ? '0 : cnt + 1'b1;
      blk <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0;
    end else if (wr_hi) begin
      stg <= wdata;
    end else if (rd_en) begin
      case (addr)
        A_CNTL:  stg <= cnt[CW-1:BW];
        A_CMAL:  stg <= cmp_a[CW-1:BW];
        A_CMBL:  stg <= cmp_b[CW-1:BW];
        default: stg <= stg;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
      ctc   <= 1'b0;
      ten_a <= 1'b0;
      ten_b <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_CMAL) cmp_a <= {stg, wdata};
      if (addr == A_CMBL) cmp_b <= {stg, wdata};
      if (addr == A_CTRL) {ten_b, ten_a, ctc} <= wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_a  <= 1'b0;
      irq_b  <= 1'b0;
      wave_a <= 1'b0;
      wave_b <= 1'b0;
    end else begin
      irq_a  <= hit_a | (irq_a & ~clr_a);
      irq_b  <= hit_b | (irq_b & ~clr_b);
      wave_a <= wave_a ^ ((hit_a && ten_a) || frc_a);
      wave_b <= wave_b ^ ((hit_b && ten_b) || frc_b);
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:  rdata = {5'b0, ten_b, ten_a, ctc};
        A_FLAG:  rdata = {6'b0, irq_b, irq_a};
        A_CNTL:  rdata = cnt[BW-1:0];
        A_CMAL:  rdata = cmp_a[BW-1:0];
        A_CMBL:  rdata = cmp_b[BW-1:0];
        default: rdata = stg;
      endcase
    end
  end
endmodule

// File: rtl/tmr16_bytebus_chk.sv
module tmr16_bytebus_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        tick,
  input logic        irq_a,
  input logic        irq_b,
  input logic        wave_a,
  input logic        wave_b,
  input logic [15:0] cnt,
  input logic [15:0] cmp_a,
  input logic        blk,
  input logic        ctc
);
  logic cw;
  assign cw = wr_en && addr == 3'd2;

  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cw) |=> $stable(cnt));
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cw && cnt == 16'hFFFF) |=> cnt == 16'h0000);
  p_ctc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !blk && !cw && ctc && cnt == cmp_a) |=> cnt == 16'h0000);
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !blk && cnt == cmp_a) |=> irq_a);
  p_block_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blk && !irq_a) |=> !irq_a);
  p_block_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blk && !irq_b) |=> !irq_b);
  p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wdata[6] && !tick && !irq_a) |=> (!irq_a && wave_a != $past(wave_a)));
  p_force_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0) |-> rdata[7:3] == 5'b0);
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && wdata[1] && !tick) |=> !irq_b);
  p_idle_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);
endmodule

bind tmr16_bytebus tmr16_bytebus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .tick(tick), .irq_a(irq_a), .irq_b(irq_b),
  .wave_a(wave_a), .wave_b(wave_b), .cnt(cnt), .cmp_a(cmp_a), .blk(blk), .ctc(ctc)
);

// File: tb/test_tmr16_bytebus.sv
module test_tmr16_bytebus;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq_a, irq_b, wave_a, wave_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr16_bytebus i_tmr16_bytebus (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tick(tick), .irq_a(irq_a), .irq_b(irq_b),
    .wave_a(wave_a), .wave_b(wave_b));

  // op: 0 write, 1 read and compare, 2 tick d times
  localparam int NV = 64;
  localparam logic [24:0] VT [NV] = '{
    {2'd0,3'd3,8'h12,8'h00,4'd2}, {2'd0,3'd2,8'h34,8'h00,4'd2},   // R2 counter = 0x1234
    {2'd1,3'd2,8'h00,8'h34,4'd2}, {2'd1,3'd3,8'h00,8'h12,4'd3},
    {2'd2,3'd0,8'd1,8'h00,4'd4},  {2'd1,3'd2,8'h00,8'h35,4'd4},   // R4 one tick
    {2'd1,3'd3,8'h00,8'h12,4'd4},
    {2'd0,3'd3,8'h12,8'h00,4'd3}, {2'd0,3'd2,8'hFF,8'h00,4'd3},   // R3 snapshot
    {2'd1,3'd2,8'h00,8'hFF,4'd3}, {2'd2,3'd0,8'd1,8'h00,4'd3},
    {2'd1,3'd3,8'h00,8'h12,4'd3}, {2'd1,3'd2,8'h00,8'h00,4'd3},
    {2'd1,3'd3,8'h00,8'h13,4'd3},
    {2'd0,3'd5,8'h00,8'h00,4'd2}, {2'd0,3'd2,8'h40,8'h00,4'd2},   // R2 shared staging
    {2'd1,3'd2,8'h00,8'h40,4'd2}, {2'd1,3'd3,8'h00,8'h00,4'd2},
    {2'd0,3'd3,8'hFF,8'h00,4'd4}, {2'd0,3'd2,8'hFE,8'h00,4'd4},   // R4 wrap
    {2'd2,3'd0,8'd2,8'h00,4'd4},  {2'd1,3'd2,8'h00,8'h00,4'd4},
    {2'd1,3'd3,8'h00,8'h00,4'd4}, {2'd1,3'd1,8'h00,8'h00,4'd6},
    {2'd2,3'd0,8'd1,8'h00,4'd6},  {2'd1,3'd1,8'h00,8'h03,4'd6},   // R6 both match 0
    {2'd0,3'd1,8'h01,8'h00,4'd9}, {2'd1,3'd1,8'h00,8'h02,4'd9},   // R9 clear
    {2'd0,3'd1,8'h02,8'h00,4'd9}, {2'd1,3'd1,8'h00,8'h00,4'd9},
    {2'd0,3'd5,8'h00,8'h00,4'd2}, {2'd0,3'd4,8'h05,8'h00,4'd2},   // compare A = 5
    {2'd1,3'd4,8'h00,8'h05,4'd2}, {2'd1,3'd5,8'h00,8'h00,4'd2},
    {2'd0,3'd7,8'h00,8'h00,4'd2}, {2'd0,3'd6,8'h03,8'h00,4'd2},   // compare B = 3
    {2'd0,3'd0,8'h01,8'h00,4'd10},{2'd1,3'd0,8'h00,8'h01,4'd10},  // R10 clear mode
    {2'd0,3'd3,8'h00,8'h00,4'd5}, {2'd0,3'd2,8'h00,8'h00,4'd5},
    {2'd2,3'd0,8'd1,8'h00,4'd5},  {2'd2,3'd0,8'd2,8'h00,4'd5},
    {2'd2,3'd0,8'd1,8'h00,4'd6},  {2'd1,3'd1,8'h00,8'h02,4'd6},
    {2'd2,3'd0,8'd1,8'h00,4'd5},  {2'd2,3'd0,8'd1,8'h00,4'd5},   // R5 match A clears
    {2'd1,3'd1,8'h00,8'h03,4'd5}, {2'd1,3'd2,8'h00,8'h00,4'd5},
    {2'd0,3'd1,8'h03,8'h00,4'd9},
    {2'd0,3'd3,8'h00,8'h00,4'd7}, {2'd0,3'd2,8'h03,8'h00,4'd7},   // R7 block B
    {2'd2,3'd0,8'd1,8'h00,4'd7},  {2'd1,3'd1,8'h00,8'h00,4'd7},
    {2'd0,3'd3,8'h00,8'h00,4'd7}, {2'd0,3'd2,8'h05,8'h00,4'd7},   // R7 block A
    {2'd2,3'd0,8'd1,8'h00,4'd7},  {2'd1,3'd1,8'h00,8'h00,4'd7},
    {2'd1,3'd2,8'h00,8'h06,4'd7},
    {2'd0,3'd3,8'h00,8'h00,4'd8}, {2'd0,3'd2,8'h05,8'h00,4'd8},   // R8 force at match
    {2'd0,3'd0,8'hC1,8'h00,4'd8}, {2'd1,3'd0,8'h00,8'h01,4'd8},
    {2'd1,3'd1,8'h00,8'h00,4'd8}, {2'd1,3'd2,8'h00,8'h05,4'd8}
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, input logic [7:0] e, input int req);
    addr = a; rd_en = 1'b1;
    #1 check(req, rdata, e);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_tick(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic wa, wb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(1, {4'b0, irq_a, irq_b, wave_a, wave_b}, 8'h00);
    for (int k = 0; k < 8; k++) do_rd(3'(k), 8'h00, 1);

    for (int i = 0; i < NV; i++) begin
      case (VT[i][24:23])
        2'd0: do_wr(VT[i][22:20], VT[i][19:12]);
        2'd1: do_rd(VT[i][22:20], VT[i][11:4], int'(VT[i][3:0]));
        default: do_tick(int'(VT[i][19:12]));
      endcase
    end

    // R8 force A only: output flips, no flag, counter untouched
    wa = wave_a; wb = wave_b;
    do_wr(3'd0, 8'h41);
    check(8, {7'b0, wave_a}, {7'b0, ~wa});
    check(8, {7'b0, wave_b}, {7'b0, wb});
    check(8, {7'b0, irq_a}, 8'h00);
    do_rd(3'd2, 8'h05, 8);

    // R4 no tick, counter holds
    repeat (5) @(negedge clk);
    do_rd(3'd2, 8'h05, 4);

    // R6 toggle on match with enables set, clear mode on
    do_wr(3'd0, 8'h07);
    do_wr(3'd3, 8'h00);
    do_wr(3'd2, 8'h04);
    do_tick(1);
    wa = wave_a; wb = wave_b;
    do_tick(1);
    check(6, {7'b0, wave_a}, {7'b0, ~wa});
    check(6, {7'b0, wave_b}, {7'b0, wb});
    check(6, {7'b0, irq_a}, 8'h01);
    do_rd(3'd2, 8'h00, 5);

    // R9 clear of B colliding with a match on B: set wins
    do_tick(3);
    addr = 3'd1; wdata = 8'h02; wr_en = 1'b1; tick = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    check(9, {7'b0, irq_b}, 8'h01);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    check(1, {4'b0, irq_a, irq_b, wave_a, wave_b}, 8'h00);
    do_rd(3'd0, 8'h00, 1);
    do_rd(3'd2, 8'h00, 1);
    do_rd(3'd4, 8'h00, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule